// File: doc/BRIEF.md
# Two-Bit Cell Line Access Sequencer

This block drives a data array in which every cell stores two bits in two stacked magnetic layers. The upper bit lives in the hard layer and the lower bit in the soft layer. Each pair of cache lines shares one row of cells. One line of the pair is formed from the hard layers. It reads fast, but writing it is costly. The other line is formed from the soft layers. It reads slower, but is cheap to write. A pair can also run in single-bit mode. In that mode the hard layers are held at zero and only the soft layers carry data.

The sequencer accepts one read or write request at a time. The request carries a line select (hard or soft), a pair-mode flag and a pair index. From these the sequencer issues an ordered series of steps to a behavioural cell array. Each sense step uses a per-bit reference selection, and each write pulse carries a per-bit mask. The sequencer raises busy for the whole operation and then gives a one-cycle done pulse. Read data is returned on done. Each step lasts a parameterised number of cycles. These durations stand in for the analog sensing and pulse timing.

Top module: `mlc_line_seq`

## Requirements
- R1: A request is accepted only when `req_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance until the operation ends. `done` is then high for exactly one cycle, with `busy` low. A request presented while `busy` is high has no effect on the array.
- R2: In two-bit mode, a hard-line read is one sense step of 3 cycles. Every bit uses the middle reference. The reference code sits in `step_ref[2b+1:2b]` for bit b: 0 means none, 1 the low reference, 2 the middle, 3 the high. `done` follows 3 cycles after acceptance, and `rdata` holds the hard-layer bits.
- R3: In two-bit mode, a soft-line read is two sense steps, 3 cycles and then 2 cycles. The first step uses the middle reference on every bit. The second step uses code 1 for bits whose hard bit is 0 and code 3 for bits whose hard bit is 1. `rdata` holds the soft-layer bits after 5 cycles.
- R4: A hard-line write runs its steps in a fixed order: a middle-reference sense, a per-bit soft sense, a hard pulse, and then a soft restore pulse (3+2+7+7 = 19 cycles). Afterwards the soft line of the pair still reads its old value.
- R5: The restore pulse mask holds exactly the bits where the saved soft value differs from the new hard value. When that mask is all zero, the restore step is skipped and the write completes in 12 cycles.
- R6: In two-bit mode, a soft-line write is a single soft pulse with an all-ones mask. It has no sense step and no hard pulse, lasts 42 cycles, and leaves the hard line unchanged.
- R7: In single-bit mode, `req_hard` is ignored. A read is one 3-cycle sense step with code 1 on every bit. A write is one 19-cycle soft pulse with an all-ones mask and no hard pulse. The hard bits of the pair stay 0.
- R8: After reset, `busy`, `done` and `rdata` are 0, no step output is active, and every cell of the array holds 0.
- R9: `rdata` keeps the result of the last completed read. Writes do not change it.
- R10: At most one of the three is active in any cycle: a hard pulse, a soft pulse, or a nonzero reference selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hard | input | 1 | 1 = hard-layer line, 0 = soft-layer line |
| req_single | input | 1 | 1 = pair in single-bit mode |
| req_pair | input | PW | Line pair index |
| req_wdata | input | W | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | W | Last read result |
| step_ref | output | 2*W | Per-bit sense reference code |
| step_hpulse | output | 1 | Hard-layer write pulse active |
| step_spulse | output | 1 | Soft-layer write pulse active |
| step_smask | output | W | Per-bit mask of the soft pulse |

## Verification
The bench builds several data patterns in the pairs. In some, the hard and soft bits are equal in some positions and differ in others. This lets the per-bit reference in the second sense step be told apart from a uniform reference. Hard-line writes are tried in two cases: with new data that differs from the saved soft bits, and with new data that matches them exactly. The first case shows the restore mask is formed per bit. The second shows the restore step is dropped. Single-bit accesses are made with the line select set both ways, followed by two-bit reads of the same pair, to show the hard layer stayed at zero. A request injected during a long soft write shows that the busy window really blocks new work.

// File: rtl/mlc_seq_pkg.sv
package mlc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SENSE_HI = 3'd1,
        ST_SENSE_LO = 3'd2,
        ST_PULSE_HI = 3'd3,
        ST_PULSE_LO = 3'd4
    } step_e;

    localparam logic [1:0] REF_NONE = 2'd0;
    localparam logic [1:0] REF_LOW  = 2'd1;
    localparam logic [1:0] REF_MID  = 2'd2;
    localparam logic [1:0] REF_HIGH = 2'd3;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mlc_seq_ctrl.sv
module mlc_seq_ctrl
    import mlc_seq_pkg::*;
#(
    parameter int unsigned W               = 8,
    parameter int unsigned PW              = 2,
    parameter int unsigned T_SENSE_HI      = 3,
    parameter int unsigned T_SENSE_LO      = 2,
    parameter int unsigned T_SENSE_SLC     = 3,
    parameter int unsigned T_PULSE_HI      = 7,
    parameter int unsigned T_PULSE_RESTORE = 7,
    parameter int unsigned T_PULSE_LO      = 42,
    parameter int unsigned T_PULSE_SLC     = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_hard,
    input  logic            req_single,
    input  logic [PW-1:0]   req_pair,
    input  logic [W-1:0]    req_wdata,
    input  logic [W-1:0]    sense_bits,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    rdata,
    output logic [2*W-1:0]  ref_sel,
    output logic            hpulse,
    output logic            spulse,
    output logic            fire,
    output logic [W-1:0]    smask,
    output logic [W-1:0]    hdata,
    output logic [W-1:0]    sdata,
    output logic [PW-1:0]   pair
);

    localparam int unsigned TMAX = max_of(
        max_of(max_of(T_SENSE_HI, T_SENSE_LO), max_of(T_SENSE_SLC, T_PULSE_HI)),
        max_of(max_of(T_PULSE_RESTORE, T_PULSE_LO), T_PULSE_SLC));
    localparam int unsigned CW = $clog2(TMAX + 1);

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        step_e          step;
        cnt_t           cnt;
        logic           wr;
        logic           hard;
        logic           single;
        logic [PW-1:0]  pair;
        logic [W-1:0]   wbuf;
        logic [W-1:0]   msb_buf;
        logic [W-1:0]   lsb_buf;
        logic [W-1:0]   rdata;
        logic           done;
    } seq_t;

    function automatic cnt_t len(input int unsigned t);
        return cnt_t'(t - 1);
    endfunction

    seq_t           q, d;
    logic           last;
    logic [W-1:0]   restore_mask;

    assign last         = (q.cnt == '0);
    assign restore_mask = q.lsb_buf ^ q.wbuf;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.step != ST_IDLE && !last) begin
            d.cnt = q.cnt - cnt_t'(1);
        end
        unique case (q.step)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr     = req_write;
                    d.hard   = req_hard & ~req_single;
                    d.single = req_single;
                    d.pair   = req_pair;
                    d.wbuf   = req_wdata;
                    if (req_single) begin
                        d.step = req_write ? ST_PULSE_LO : ST_SENSE_LO;
                        d.cnt  = req_write ? len(T_PULSE_SLC) : len(T_SENSE_SLC);
                    end else if (req_write && !req_hard) begin
                        d.step = ST_PULSE_LO;
                        d.cnt  = len(T_PULSE_LO);
                    end else begin
                        d.step = ST_SENSE_HI;
                        d.cnt  = len(T_SENSE_HI);
                    end
                end
            end
            ST_SENSE_HI: begin
                if (last) begin
                    d.msb_buf = sense_bits;
                    if (!q.wr && q.hard) begin
                        d.step  = ST_IDLE;
                        d.done  = 1'b1;
                        d.rdata = sense_bits;
                    end else begin
                        d.step = ST_SENSE_LO;
                        d.cnt  = len(T_SENSE_LO);
                    end
                end
            end
            ST_SENSE_LO: begin
                if (last) begin
                    d.lsb_buf = sense_bits;
                    if (!q.wr) begin
                        d.step  = ST_IDLE;
                        d.done  = 1'b1;
                        d.rdata = sense_bits;
                    end else begin
                        d.step = ST_PULSE_HI;
                        d.cnt  = len(T_PULSE_HI);
                    end
                end
            end
            ST_PULSE_HI: begin
                if (last) begin
                    if (restore_mask != '0) begin
                        d.step = ST_PULSE_LO;
                        d.cnt  = len(T_PULSE_RESTORE);
                    end else begin
                        d.step = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            ST_PULSE_LO: begin
                if (last) begin
                    d.step = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int b = 0; b < W; b++) begin
            unique case (q.step)
                ST_SENSE_HI: ref_sel[2*b +: 2] = REF_MID;
                ST_SENSE_LO: ref_sel[2*b +: 2] = (q.single || !q.msb_buf[b]) ? REF_LOW : REF_HIGH;
                default:     ref_sel[2*b +: 2] = REF_NONE;
            endcase
        end
    end

    assign busy   = (q.step != ST_IDLE);
    assign done   = q.done;
    assign rdata  = q.rdata;
    assign fire   = busy && last;
    assign hpulse = (q.step == ST_PULSE_HI);
    assign spulse = (q.step == ST_PULSE_LO);
    assign hdata  = q.wbuf;
    assign smask  = q.hard ? restore_mask : '1;
    assign sdata  = q.hard ? q.lsb_buf : q.wbuf;
    assign pair   = q.pair;

endmodule

// File: rtl/mlc_cell_array.sv
module mlc_cell_array
    import mlc_seq_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned PAIRS = 4,
    parameter int unsigned PW    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   pair,
    input  logic [2*W-1:0]  ref_sel,
    input  logic            fire,
    input  logic            hpulse,
    input  logic            spulse,
    input  logic [W-1:0]    hdata,
    input  logic [W-1:0]    smask,
    input  logic [W-1:0]    sdata,
    output logic [W-1:0]    sense_bits
);

    logic [W-1:0] hi_q [PAIRS];
    logic [W-1:0] lo_q [PAIRS];
    logic [W-1:0] hi_d [PAIRS];
    logic [W-1:0] lo_d [PAIRS];

    // Resistance level per bit is {hard, soft}; a reference k reports level >= k.
    always_comb begin
        for (int b = 0; b < W; b++) begin
            sense_bits[b] = (ref_sel[2*b +: 2] != REF_NONE) &&
                            ({hi_q[pair][b], lo_q[pair][b]} >= ref_sel[2*b +: 2]);
        end
    end

    // A hard pulse also drags the soft layer to the same value.
    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (fire && hpulse) begin
            hi_d[pair] = hdata;
            lo_d[pair] = hdata;
        end
        if (fire && spulse) begin
            lo_d[pair] = (lo_q[pair] & ~smask) | (sdata & smask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAIRS; i++) begin
                hi_q[i] <= '0;
                lo_q[i] <= '0;
            end
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

endmodule

// File: rtl/mlc_line_seq.sv
module mlc_line_seq #(
    parameter int unsigned W               = 8,
    parameter int unsigned PAIRS           = 4,
    parameter int unsigned T_SENSE_HI      = 3,
    parameter int unsigned T_SENSE_LO      = 2,
    parameter int unsigned T_SENSE_SLC     = 3,
    parameter int unsigned T_PULSE_HI      = 7,
    parameter int unsigned T_PULSE_RESTORE = 7,
    parameter int unsigned T_PULSE_LO      = 42,
    parameter int unsigned T_PULSE_SLC     = 19,
    localparam int unsigned PW             = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_hard,
    input  logic            req_single,
    input  logic [PW-1:0]   req_pair,
    input  logic [W-1:0]    req_wdata,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    rdata,
    output logic [2*W-1:0]  step_ref,
    output logic            step_hpulse,
    output logic            step_spulse,
    output logic [W-1:0]    step_smask
);

    logic [W-1:0]  sense_bits;
    logic          fire;
    logic [W-1:0]  hdata;
    logic [W-1:0]  sdata;
    logic [PW-1:0] pair;

    mlc_seq_ctrl #(
        .W(W), .PW(PW),
        .T_SENSE_HI(T_SENSE_HI), .T_SENSE_LO(T_SENSE_LO), .T_SENSE_SLC(T_SENSE_SLC),
        .T_PULSE_HI(T_PULSE_HI), .T_PULSE_RESTORE(T_PULSE_RESTORE),
        .T_PULSE_LO(T_PULSE_LO), .T_PULSE_SLC(T_PULSE_SLC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_hard(req_hard),
        .req_single(req_single), .req_pair(req_pair), .req_wdata(req_wdata),
        .sense_bits(sense_bits),
        .busy(busy), .done(done), .rdata(rdata),
        .ref_sel(step_ref), .hpulse(step_hpulse), .spulse(step_spulse),
        .fire(fire), .smask(step_smask), .hdata(hdata), .sdata(sdata), .pair(pair)
    );

    mlc_cell_array #(
        .W(W), .PAIRS(PAIRS), .PW(PW)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .pair(pair), .ref_sel(step_ref),
        .fire(fire), .hpulse(step_hpulse), .spulse(step_spulse),
        .hdata(hdata), .smask(step_smask), .sdata(sdata),
        .sense_bits(sense_bits)
    );

endmodule

// File: rtl/mlc_line_seq_chk.sv
module mlc_line_seq_chk #(
    parameter int unsigned W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_single,
    input logic           busy,
    input logic           done,
    input logic           step_hpulse,
    input logic           step_spulse,
    input logic [2*W-1:0] step_ref
);

    logic single_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_lat <= 1'b0;
        end else if (req_valid && !busy) begin
            single_lat <= req_single;
        end
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R1
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_hpulse, step_spulse, |step_ref}));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!step_hpulse && !step_spulse && step_ref == '0));

    // R7
    single_no_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && single_lat) |-> !step_hpulse);

endmodule

bind mlc_line_seq mlc_line_seq_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_single(req_single),
    .busy(busy), .done(done), .step_hpulse(step_hpulse),
    .step_spulse(step_spulse), .step_ref(step_ref)
);

// File: tb/tb_mlc_line_seq.sv
module tb_mlc_line_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_hard = 1'b0;
    logic        req_single = 1'b0;
    logic [1:0]  req_pair = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rdata;
    logic [15:0] step_ref;
    logic        step_hpulse, step_spulse;
    logic [7:0]  step_smask;

    int n_chk = 0;
    int n_err = 0;

    // Per-operation observations
    int          lat, n_mid, n_per, n_hp, n_sp;
    logic [15:0] pat, order;
    logic [7:0]  mask_seen;
    bit          busy_gap;

    mlc_line_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_hard(req_hard), .req_single(req_single), .req_pair(req_pair),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .step_ref(step_ref), .step_hpulse(step_hpulse), .step_spulse(step_spulse),
        .step_smask(step_smask)
    );

    always #4ns clk = ~clk;

    typedef struct packed {
        logic       wr;
        logic       hd;
        logic       sg;
        logic [1:0] p;
        logic [7:0] d;
        logic [7:0] lat;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 2'd0, 8'hA5, 8'd42, 8'h00},
        '{1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'd5,  8'hA5},
        '{1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 8'd3,  8'h00},
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'h3C, 8'd19, 8'h00},
        '{1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 8'd3,  8'h3C},
        '{1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'd5,  8'hA5},
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'hA5, 8'd12, 8'hA5},
        '{1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'd5,  8'hA5},
        '{1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 8'd3,  8'hA5},
        '{1'b1, 1'b0, 1'b0, 2'd1, 8'h0F, 8'd42, 8'hA5},
        '{1'b1, 1'b1, 1'b0, 2'd1, 8'hF0, 8'd19, 8'hA5},
        '{1'b0, 1'b0, 1'b0, 2'd1, 8'h00, 8'd5,  8'h0F},
        '{1'b0, 1'b1, 1'b0, 2'd1, 8'h00, 8'd3,  8'hF0},
        '{1'b1, 1'b1, 1'b1, 2'd2, 8'h5A, 8'd19, 8'hF0},
        '{1'b0, 1'b0, 1'b1, 2'd2, 8'h00, 8'd3,  8'h5A},
        '{1'b0, 1'b1, 1'b1, 2'd2, 8'h00, 8'd3,  8'h5A},
        '{1'b0, 1'b1, 1'b0, 2'd2, 8'h00, 8'd3,  8'h00},
        '{1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'd5,  8'h5A},
        '{1'b0, 1'b1, 1'b0, 2'd3, 8'h00, 8'd3,  8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic wr, input logic hd,
                                     input logic sg, input logic [7:0] l);
        if (sg) return "R7";
        if (wr && hd) return (l == 8'd12) ? "R5" : "R4";
        if (wr) return "R6";
        if (hd) return "R2";
        return "R3";
    endfunction

    task automatic do_op(input logic wr, input logic hd, input logic sg,
                         input logic [1:0] p, input logic [7:0] dat, input bit inject);
        int k;
        logic [3:0] kind, prev;
        bit fin;
        k = 0; prev = '0; fin = 1'b0;
        n_mid = 0; n_per = 0; n_hp = 0; n_sp = 0;
        pat = '0; order = '0; mask_seen = '0; busy_gap = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_hard = hd;
        req_single = sg; req_pair = p; req_wdata = dat;
        while (!fin) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (inject && k == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_hard = 1'b1;
                req_single = 1'b0; req_pair = 2'd0; req_wdata = 8'hFF;
            end
            if (inject && k == 4) req_valid = 1'b0;
            if (done) begin
                fin = 1'b1;
            end else if (k > 2000) begin
                n_err++;
                $display("FAIL R1 timeout: actual no done expected done");
                fin = 1'b1;
            end else begin
                if (!busy) busy_gap = 1'b1;
                if (step_hpulse)             kind = 4'd3;
                else if (step_spulse)        kind = 4'd4;
                else if (step_ref == 16'hAAAA) kind = 4'd1;
                else if (step_ref != '0)     kind = 4'd2;
                else                         kind = 4'd0;
                case (kind)
                    4'd1: n_mid++;
                    4'd2: begin n_per++; pat = step_ref; end
                    4'd3: n_hp++;
                    4'd4: begin n_sp++; mask_seen = step_smask; end
                    default: ;
                endcase
                if (kind != prev && kind != 4'd0) order = {order[11:0], kind};
                prev = kind;
                k++;
            end
        end
        lat = k;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8", busy, 0, "busy after reset");
        chk("R8", done, 0, "done after reset");
        chk("R8", rdata, 0, "rdata after reset");
        chk("R8", {step_hpulse, step_spulse, step_ref}, 0, "step outputs after reset");

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i].wr, VEC[i].hd, VEC[i].sg, VEC[i].p, VEC[i].d, 1'b0);
            chk(tag_of(VEC[i].wr, VEC[i].hd, VEC[i].sg, VEC[i].lat), lat, VEC[i].lat, "latency");
            chk(VEC[i].wr ? "R9" : tag_of(VEC[i].wr, VEC[i].hd, VEC[i].sg, VEC[i].lat),
                rdata, VEC[i].exp, "rdata");
        end

        // R4 / R5: hard write step order, restore mask, soft line kept
        do_op(1'b1, 1'b0, 1'b0, 2'd3, 8'h81, 1'b0);
        do_op(1'b1, 1'b1, 1'b0, 2'd3, 8'hC3, 1'b0);
        chk("R4", order, 16'h1234, "step order");
        chk("R4", {n_mid[7:0], n_per[7:0], n_hp[7:0], n_sp[7:0]}, 32'h03020707, "step cycles");
        chk("R5", mask_seen, 8'h42, "restore mask");
        chk("R3", pat, 16'h5555, "soft sense refs with hard zero");
        do_op(1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 1'b0);
        chk("R4", rdata, 8'h81, "soft line kept across hard write");
        chk("R3", order, 16'h0012, "soft read order");
        chk("R3", pat, 16'hF55F, "per-bit refs");

        // R6: soft write is a single full-mask pulse
        do_op(1'b1, 1'b0, 1'b0, 2'd3, 8'h7E, 1'b0);
        chk("R6", order, 16'h0004, "soft write order");
        chk("R6", {n_hp[7:0], n_sp[7:0]}, 16'h002A, "pulse cycles");
        chk("R6", mask_seen, 8'hFF, "soft write mask");
        do_op(1'b0, 1'b1, 1'b0, 2'd3, 8'h00, 1'b0);
        chk("R6", rdata, 8'hC3, "hard line unchanged");
        do_op(1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 1'b0);
        chk("R6", rdata, 8'h7E, "soft line written");

        // R7: single-bit mode
        do_op(1'b1, 1'b1, 1'b1, 2'd2, 8'h66, 1'b0);
        chk("R7", order, 16'h0004, "single write order");
        chk("R7", mask_seen, 8'hFF, "single write mask");
        do_op(1'b0, 1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        chk("R7", order, 16'h0002, "single read order");
        chk("R7", pat, 16'h5555, "single read refs");
        chk("R7", rdata, 8'h66, "single read data");
        do_op(1'b0, 1'b1, 1'b0, 2'd2, 8'h00, 1'b0);
        chk("R7", rdata, 8'h00, "hard bits stay zero");

        // R2: hard read step
        do_op(1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0);
        chk("R2", order, 16'h0001, "hard read order");
        chk("R2", n_mid, 3, "hard read sense cycles");

        // R1: request while busy is ignored
        do_op(1'b1, 1'b0, 1'b0, 2'd3, 8'h11, 1'b1);
        chk("R1", lat, 42, "busy window");
        chk("R1", busy_gap, 0, "busy held");
        do_op(1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0);
        chk("R1", rdata, 8'hA5, "injected write ignored");
        @(negedge clk);
        chk("R1", {busy, done}, 0, "idle after done");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule